// File: doc/BRIEF.md
# I2C EEPROM Slave Interface

This block is the bus-facing front end of a small serial EEPROM. It is always a slave and never drives SCL. It oversamples the SCL and SDA pins on the system clock, passes them through a two-flop synchronizer and finds Start and Stop conditions and SCL edges. It then moves bytes between the bus and a simple memory port. SDA is open-drain: the block only raises a pull-low enable. It does this to acknowledge a byte and to send the zero bits of read data. Read bits change just after SCL falls.

The first byte after a Start holds a 7-bit device address and a direction bit. In a write, the next byte loads the internal word pointer and every later byte becomes one write strobe on the memory port. When a Stop ends a write that carried data, the block pulses a request for the self-timed write cycle. While the memory reports that cycle as busy, the bus is ignored. In a read, bytes come from the pointer location, and the pointer advances after each byte. If the master answers a byte with NoAck, the block releases the bus and goes back to standby. The system clock must run at least eight times faster than SCL.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, `sda_pull_o`, `mem_we_o` and `wr_start_o` are all 0.
- R2: Bits clocked in before any Start condition (an SDA fall while SCL is high) are ignored: no acknowledge and no memory write.
- R3: The first byte after a Start is bits [7:1] = device address (`DEV_ADDR`, default 7'h50) and bit 0 = direction (0 write, 1 read), sent MSB first. On a match the block holds SDA low during the ninth SCL pulse. On a mismatch there is no acknowledge, and every byte up to the next Start is ignored.
- R4: In a write, the byte after the address byte sets the word pointer. Each later byte gives one single-cycle `mem_we_o` with `mem_addr_o` = pointer and `mem_wdata_o` = byte, and is acknowledged. The pointer then advances by one and wraps modulo 2^AW.
- R5: A Stop (an SDA rise while SCL is high) that ends a write which carried at least one data byte gives exactly one single-cycle `wr_start_o` pulse. A Stop after only a word-address byte gives no pulse.
- R6: While `wr_busy_i` is high, Start conditions are not detected: an address byte sent then gets no acknowledge, and no write happens.
- R7: In a read, each byte is taken from `mem_rdata_i` (combinational data for `mem_addr_o`), sent MSB first, and the pointer advances by one per byte. A read that directly follows a write of only the word address starts at that address.
- R8: A master acknowledge (SDA low on the ninth clock of a read byte) makes the next byte follow. A NoAck releases SDA, and the block then stays off the bus until the next Start.
- R9: A repeated Start in the middle of a transaction restarts the address phase, so a word-address write followed by a read gives a random read.
- R10: `sda_pull_o` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level (wired bus) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| mem_addr_o | output | AW | Word pointer / memory address |
| mem_wdata_o | output | 8 | Byte to write |
| mem_we_o | output | 1 | Single-cycle write strobe |
| mem_rdata_i | input | 8 | Read data for `mem_addr_o` |
| wr_start_o | output | 1 | Single-cycle request to start the write cycle |
| wr_busy_i | input | 1 | Write cycle in progress |

## Verification
The bench sends a Start and an address byte while the write cycle is still busy. A design that did not blind Start detection would acknowledge that byte. It writes two bytes starting at the top word address. A pointer that saturated instead of wrapping would misplace the second byte. It answers a read with NoAck and then keeps clocking. A design that missed standby would keep pulling SDA low. It also sends a Stop after only a word address, and a pulse there would start an empty write cycle. Further cases are an address mismatch followed by data, a repeated-Start random read, and bits clocked before any Start.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_t;

  typedef enum logic [1:0] {
    BY_DEV,
    BY_WORD,
    BY_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2cs_rstsync.sv
module i2cs_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      meta   <= 1'b1;
      rst_sn <= meta;
    end
  end
endmodule

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_p;
  logic              sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              wr_busy_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              sda_pull_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              wr_start_o
);
  phase_t            phase, phase_n;
  byte_kind_t        kind, kind_n;
  logic              rw, rw_n;
  logic [3:0]        cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic [BYTE_W-1:0] tx, tx_n;
  logic [AW-1:0]     ptr, ptr_n;
  logic              pull, pull_n;
  logic              wrote, wrote_n;
  logic              macked, macked_n;
  logic              we, we_n;
  logic              wst, wst_n;

  always_comb begin
    phase_n  = phase;
    kind_n   = kind;
    rw_n     = rw;
    cnt_n    = cnt;
    sh_n     = sh;
    tx_n     = tx;
    ptr_n    = ptr;
    pull_n   = pull;
    wrote_n  = wrote;
    macked_n = macked;
    we_n     = 1'b0;
    wst_n    = 1'b0;
    if (wr_busy_i) begin
      phase_n = PH_IDLE;
      pull_n  = 1'b0;
      wrote_n = 1'b0;
    end else if (start_evt) begin
      phase_n = PH_RX;
      kind_n  = BY_DEV;
      cnt_n   = 4'd0;
      pull_n  = 1'b0;
      wrote_n = 1'b0;
    end else if (stop_evt) begin
      phase_n = PH_IDLE;
      pull_n  = 1'b0;
      wst_n   = wrote;
      wrote_n = 1'b0;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt_n = 4'd0;
            unique case (kind)
              BY_DEV: begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw_n    = sh[0];
                  pull_n  = 1'b1;
                  phase_n = PH_ACK;
                end else begin
                  phase_n = PH_IDLE;
                end
              end
              BY_WORD: begin
                ptr_n   = sh[AW-1:0];
                pull_n  = 1'b1;
                phase_n = PH_ACK;
              end
              default: begin
                we_n    = 1'b1;
                wrote_n = 1'b1;
                pull_n  = 1'b1;
                phase_n = PH_ACK;
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            if (kind == BY_DEV && rw) begin
              tx_n    = mem_rdata_i;
              pull_n  = ~mem_rdata_i[7];
              ptr_n   = ptr + AW'(1);
              cnt_n   = 4'd1;
              phase_n = PH_TX;
            end else begin
              pull_n  = 1'b0;
              cnt_n   = 4'd0;
              phase_n = PH_RX;
              if (kind == BY_DATA) ptr_n = ptr + AW'(1);
              kind_n = (kind == BY_DEV) ? BY_WORD : BY_DATA;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              pull_n  = 1'b0;
              phase_n = PH_MACK;
            end else begin
              tx_n   = {tx[BYTE_W-2:0], tx[BYTE_W-1]};
              pull_n = ~tx[BYTE_W-2];
              cnt_n  = cnt + 4'd1;
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            macked_n = ~sda_s;
          end else if (scl_fall) begin
            if (macked) begin
              tx_n    = mem_rdata_i;
              pull_n  = ~mem_rdata_i[7];
              ptr_n   = ptr + AW'(1);
              cnt_n   = 4'd1;
              phase_n = PH_TX;
            end else begin
              phase_n = PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      kind   <= BY_DEV;
      rw     <= 1'b0;
      cnt    <= 4'd0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      pull   <= 1'b0;
      wrote  <= 1'b0;
      macked <= 1'b0;
      we     <= 1'b0;
      wst    <= 1'b0;
    end else begin
      phase  <= phase_n;
      kind   <= kind_n;
      rw     <= rw_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      tx     <= tx_n;
      ptr    <= ptr_n;
      pull   <= pull_n;
      wrote  <= wrote_n;
      macked <= macked_n;
      we     <= we_n;
      wst    <= wst_n;
    end
  end

  assign sda_pull_o  = pull;
  assign mem_addr_o  = ptr;
  assign mem_wdata_o = sh;
  assign mem_we_o    = we;
  assign wr_start_o  = wst;
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import i2cs_pkg::*;
#(
  parameter int         AW        = 8,
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              wr_start_o,
  input  logic              wr_busy_i
);
  logic rst_sn;
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2cs_rstsync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  i2cs_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sn),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2cs_ctrl #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sn),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .wr_busy_i   (wr_busy_i),
    .mem_rdata_i (mem_rdata_i),
    .sda_pull_o  (sda_pull_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .wr_start_o  (wr_start_o)
  );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic stop_evt,
  input logic sda_pull_o,
  input logic mem_we_o,
  input logic wr_start_o,
  input logic wr_busy_i
);
  // R10: the pull-low enable never moves while SCL stays high
  a_r10_pull_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));

  // R5: write-cycle request follows a detected Stop
  a_r5_start_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |-> $past(stop_evt));

  // R5: request is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |=> !wr_start_o);

  // R4: write strobe is a single-cycle pulse
  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);

  // R6: nothing is driven or written while the write cycle runs
  a_r6_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy_i |-> (!sda_pull_o && !mem_we_o));
endmodule

bind eeprom_i2c_slave i2cs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .stop_evt   (stop_evt),
  .sda_pull_o (sda_pull_o),
  .mem_we_o   (mem_we_o),
  .wr_start_o (wr_start_o),
  .wr_busy_i  (wr_busy_i)
);

// File: tb/tb_eeprom_i2c_slave.sv
module tb_eeprom_i2c_slave;
  localparam int CLK_P    = 10;
  localparam int Q        = 4;
  localparam int BUSY_LEN = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_pull;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, wr_start, wr_busy;
  logic [7:0] model [256];
  logic [7:0] expv  [256];
  logic [15:0] wq[$];
  int total = 0, bad = 0, wst_cnt = 0, busy_cnt = 0;
  logic [7:0] wptr;
  bit ack, ok;
  logic [7:0] rd;

  always #(CLK_P/2) clk = ~clk;

  assign sda_line  = sda_m & ~sda_pull;
  assign mem_rdata = model[mem_addr];
  assign wr_busy   = (busy_cnt != 0);

  eeprom_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .wr_start_o(wr_start),
    .wr_busy_i(wr_busy)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (mem_we) model[mem_addr] <= mem_wdata;

  always @(negedge clk) begin
    if (wr_start) begin
      wst_cnt++;
      busy_cnt = BUSY_LEN;
    end else if (busy_cnt > 0) busy_cnt--;
  end

  // scoreboard monitor: each write strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (wq.size() == 0) chk(1'b0, "R4 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [15:0] e;
        e = wq.pop_front();
        chk({mem_addr, mem_wdata} == e, "R4 write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitc(Q);
    scl = 1'b1;   waitc(2*Q);
    sda_m = 1'b0; waitc(2*Q);
    scl = 1'b0;
  endtask

  task automatic i2c_stop();
    waitc(Q); sda_m = 1'b0;
    waitc(Q); scl = 1'b1;
    waitc(2*Q); sda_m = 1'b1;
    waitc(2*Q);
  endtask

  task automatic clock_bit(input bit b, output bit seen);
    waitc(Q); sda_m = b;
    waitc(Q); scl = 1'b1;
    waitc(Q); seen = sda_line;
    waitc(Q); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    clock_bit(!mack, s);
  endtask

  // driver: sends a data byte and pushes the expected memory write
  task automatic write_data(input logic [7:0] b, output bit acked);
    wq.push_back({wptr, b});
    expv[wptr] = b;
    wptr = wptr + 8'd1;
    send_byte(b, acked);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      model[i] = 8'(i) ^ 8'h3C;
      expv[i]  = 8'(i) ^ 8'h3C;
    end
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    // R1 reset state
    chk(!sda_pull && !mem_we && !wr_start, "R1 reset outputs", {sda_pull, mem_we, wr_start}, 0);

    // R2 bits without a Start
    send_byte(8'hA0, ack);
    chk(!ack, "R2 no ack before Start", ack, 0);

    // R3 R4 R5 write of three bytes
    i2c_start();
    send_byte(8'hA0, ack); chk(ack, "R3 address match ack", ack, 1);
    send_byte(8'h10, ack); chk(ack, "R4 word address ack", ack, 1);
    wptr = 8'h10;
    write_data(8'hC3, ack); chk(ack, "R4 data ack", ack, 1);
    write_data(8'h5E, ack);
    write_data(8'h81, ack);
    i2c_stop();
    waitc(4);
    chk(wst_cnt == 1, "R5 one write-cycle request", wst_cnt, 1);
    chk(wq.size() == 0, "R4 all writes seen", wq.size(), 0);

    // R6 Start ignored while busy
    chk(wr_busy, "R6 busy active", wr_busy, 1);
    i2c_start();
    send_byte(8'hA0, ack); chk(!ack, "R6 no ack while busy", ack, 0);
    i2c_stop();
    wait (!wr_busy); waitc(20);
    chk(wst_cnt == 1, "R6 no extra request", wst_cnt, 1);

    // R4 pointer wrap
    i2c_start();
    send_byte(8'hA0, ack);
    send_byte(8'hFF, ack);
    wptr = 8'hFF;
    write_data(8'h5A, ack);
    write_data(8'hA5, ack); chk(ack, "R4 wrap data ack", ack, 1);
    i2c_stop();
    waitc(4);
    chk(wst_cnt == 2, "R5 second request", wst_cnt, 2);
    wait (!wr_busy); waitc(20);

    // R5 Stop after word address only, then R7 current read
    i2c_start();
    send_byte(8'hA0, ack);
    send_byte(8'h11, ack);
    i2c_stop();
    waitc(10);
    chk(wst_cnt == 2, "R5 no request without data", wst_cnt, 2);
    i2c_start();
    send_byte(8'hA1, ack); chk(ack, "R3 read address ack", ack, 1);
    read_byte(1'b1, rd); chk(rd == expv[8'h11], "R7 current read byte0", rd, expv[8'h11]);
    read_byte(1'b0, rd); chk(rd == expv[8'h12], "R7 read byte1", rd, expv[8'h12]);
    i2c_stop();

    // R9 random read through repeated Start, R8 continuation and NoAck
    i2c_start();
    send_byte(8'hA0, ack);
    send_byte(8'hFF, ack);
    i2c_start();
    send_byte(8'hA1, ack); chk(ack, "R9 repeated Start ack", ack, 1);
    read_byte(1'b1, rd); chk(rd == expv[8'hFF], "R9 random read", rd, expv[8'hFF]);
    read_byte(1'b1, rd); chk(rd == expv[8'h00], "R8 continued read wraps", rd, expv[8'h00]);
    read_byte(1'b0, rd); chk(rd == expv[8'h01], "R8 last byte", rd, expv[8'h01]);
    ok = 1'b1;
    for (int i = 0; i < 18; i++) begin
      bit s;
      clock_bit(1'b1, s);
      if (!s) ok = 1'b0;
    end
    chk(ok, "R8 standby after NoAck", ok, 1);
    i2c_stop();

    // R3 mismatched address ignores following bytes
    i2c_start();
    send_byte(8'hA2, ack); chk(!ack, "R3 mismatch no ack", ack, 0);
    send_byte(8'h77, ack); chk(!ack, "R3 bytes ignored after mismatch", ack, 0);
    i2c_stop();
    waitc(10);
    chk(wst_cnt == 2, "R3 no request after mismatch", wst_cnt, 2);
    chk(wq.size() == 0, "R4 queue empty at end", wq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule